// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether an incoming Ethernet frame should be kept, using only its 48-bit destination address. The address arrives as six bytes, one per valid cycle, and a start strobe marks the first byte. For an individual (unicast) address, the block compares all six bytes against a programmed station address. For a group (multicast) address, it runs a CRC-32 over the bytes as they arrive and uses six bits of the result to pick one bit of a 64-bit hash table. That bit decides whether the frame is kept. The all-ones broadcast address is always kept.

The hash table lives inside the block. Software loads it one 32-bit word at a time through a small write port. The station address and the multicast-hash enable are plain inputs. One cycle after the sixth byte, the block pulses a decision strobe. With the strobe it gives the accept result, a multicast flag and the hash index that was used, so a MAC receive path can drop the frame before it is buffered.

Top module: `dest_addr_filter`

## Requirements
- R1: The CRC register is set to 0xFFFFFFFF on the first byte. Bytes are used in arrival order, each least significant bit first. For each data bit: if the register's bit 31 XOR the data bit is 1, the register shifts left by one and is XORed with 0x04C11DB7; otherwise it only shifts left by one.
- R2: After the sixth byte, the CRC is inverted. Bits 31..26 of the inverted value are the hash index k, and it is presented on `dec_hash_idx` together with the decision strobe.
- R3: Bit 5 of k picks the table word (0 = low word, 1 = high word). Bits 4..0 of k pick the bit inside that word.
- R4: The address is unicast when bit 0 of the first byte is 0. A unicast address is accepted only when byte 0..3 equal `sta_lo[7:0]`, `[15:8]`, `[23:16]`, `[31:24]` and bytes 4..5 equal `sta_hi[7:0]`, `[15:8]`.
- R5: A multicast address that is not broadcast is accepted only when `mc_hash_en` is 1 and table bit k is 1.
- R6: Both table words are zero after reset and change only through a write. On a write (`tbl_we`=1), `tbl_sel`=0 loads `tbl_wdata` into the low word and `tbl_sel`=1 loads it into the high word.
- R7: The all-ones address is accepted whatever the table contents and `mc_hash_en`.
- R8: `dec_valid` is high for exactly one cycle, in the cycle after the sixth byte is taken. It is never high otherwise. `dec_multicast` equals bit 0 of the first byte.
- R9: A byte taken with `in_start`=1 always begins a new address and discards any partial one. Valid bytes without `in_start` while no address is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_start | input | 1 | Marks the first address byte (qualified by in_valid) |
| in_valid | input | 1 | An address byte is present on in_byte |
| in_byte | input | 8 | Address byte |
| sta_lo | input | 32 | Station address bytes 0..3, byte 0 in bits 7:0 |
| sta_hi | input | 16 | Station address bytes 4..5, byte 4 in bits 7:0 |
| mc_hash_en | input | 1 | Enables hash acceptance of multicast addresses |
| tbl_we | input | 1 | Hash table word write enable |
| tbl_sel | input | 1 | Table word select: 0 low, 1 high |
| tbl_wdata | input | 32 | Table word write data |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_multicast | output | 1 | Address was a group address |
| dec_hash_idx | output | 6 | Hash index used for the decision |

## Verification
The assertions check the following on every cycle:
- The decision strobe follows the sixth byte by exactly one cycle and appears at no other time.
- The byte counter never leaves its range, and stray bytes never start an address.
- A table word changes only in the cycle after a write aimed at it.
- A broadcast is always accepted, and a multicast acceptance never happens while hashing is disabled.

Only the bench's scenarios can show the rest:
- That the CRC bit order and polynomial give the right index.
- That the index picks the right word and bit.
- That the station byte mapping is right.
- That a restart mid-address discards the partial bytes.

It does this by comparing against a reflected-form CRC model and a shadow copy of the table.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int IDX_W      = 6;
  localparam int WORD_W     = 32;
  localparam int TBL_BITS   = 1 << IDX_W;
  localparam int TBL_WORDS  = TBL_BITS / WORD_W;
  localparam int SEL_W      = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1;
  localparam int BIT_W      = $clog2(WORD_W);
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // Advance the MSB-first register by one byte fed LSB first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int j = 0; j < 8; j++) begin
      if (r[31] ^ b[j]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  // Hash index: upper bits of the inverted register.
  function automatic logic [IDX_W-1:0] hash_index(input logic [31:0] c);
    logic [31:0] f;
    f = ~c;
    return f[31 -: IDX_W];
  endfunction
endpackage

// File: rtl/dafilt_capture.sv
module dafilt_capture
  import dafilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              last_w,
  output logic [ADDR_W-1:0] addr_w,
  output logic [IDX_W-1:0]  idx_w
);
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;
  logic [31:0]       crc_q;
  logic [ADDR_W-1:0] addr_q;

  logic              take_first, take_more, take;
  logic [CNT_W-1:0]  pos;
  logic [31:0]       crc_base, crc_next;

  assign take_first = in_valid & in_start;
  assign take_more  = in_valid & ~in_start & active_q;
  assign take       = take_first | take_more;
  assign pos        = take_first ? '0 : cnt_q;
  assign crc_base   = take_first ? CRC_SEED : crc_q;
  assign crc_next   = crc_step_byte(crc_base, in_byte);
  assign last_w     = take && (pos == CNT_W'(ADDR_BYTES - 1));
  assign idx_w      = hash_index(crc_next);

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_BYTES; gi++) begin : g_byte
      assign addr_w[gi*8 +: 8] = (take && pos == CNT_W'(gi)) ? in_byte : addr_q[gi*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      crc_q    <= CRC_SEED;
      addr_q   <= '0;
    end else if (take) begin
      crc_q    <= crc_next;
      addr_q   <= addr_w;
      cnt_q    <= last_w ? '0 : pos + CNT_W'(1);
      active_q <= ~last_w;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(ADDR_BYTES)); // R9
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !(in_valid && in_start)) |=> (!active_q && cnt_q == '0)); // R9
endmodule

// File: rtl/dafilt_table.sv
module dafilt_table
  import dafilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit
);
  logic [TBL_WORDS-1:0][WORD_W-1:0] tbl_q;
  logic [SEL_W-1:0] rd_word;
  logic [BIT_W-1:0] rd_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < TBL_WORDS; w++)
        if (wr_sel == SEL_W'(w)) tbl_q[w] <= wr_data;
    end
  end

  assign rd_word = rd_idx[IDX_W-1 -: SEL_W];
  assign rd_pos  = rd_idx[BIT_W-1:0];
  assign rd_bit  = tbl_q[rd_word][rd_pos];

  genvar gw;
  generate
    for (gw = 0; gw < TBL_WORDS; gw++) begin : g_chk
      AST_WORD_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_q[gw] != $past(tbl_q[gw])) |-> $past(wr_en && wr_sel == SEL_W'(gw))); // R6
    end
  endgenerate
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
  import dafilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr_w,
  input  logic [IDX_W-1:0]  idx_w,
  input  logic              tbl_bit,
  input  logic [31:0]       sta_lo,
  input  logic [15:0]       sta_hi,
  input  logic              mc_en,
  output logic              bcast_w,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_multicast,
  output logic [IDX_W-1:0]  dec_hash_idx
);
  logic mc_w, uc_hit, hit;

  assign mc_w    = addr_w[0];
  assign bcast_w = &addr_w;
  assign uc_hit  = (addr_w == {sta_hi, sta_lo});
  assign hit     = bcast_w | (mc_w ? (mc_en & tbl_bit) : uc_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid     <= 1'b0;
      dec_accept    <= 1'b0;
      dec_multicast <= 1'b0;
      dec_hash_idx  <= '0;
    end else begin
      dec_valid <= fire;
      if (fire) begin
        dec_accept    <= hit;
        dec_multicast <= mc_w;
        dec_hash_idx  <= idx_w;
      end
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import dafilt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic [31:0] sta_lo,
  input  logic [15:0] sta_hi,
  input  logic        mc_hash_en,
  input  logic        tbl_we,
  input  logic        tbl_sel,
  input  logic [31:0] tbl_wdata,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_multicast,
  output logic [5:0]  dec_hash_idx
);
  logic              last_w;
  logic [ADDR_W-1:0] addr_w;
  logic [IDX_W-1:0]  idx_w;
  logic              tbl_bit;
  logic              bcast_w;

  dafilt_capture u_cap (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_valid(in_valid),
    .in_byte(in_byte), .last_w(last_w), .addr_w(addr_w), .idx_w(idx_w)
  );

  dafilt_table u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_sel(SEL_W'(tbl_sel)),
    .wr_data(tbl_wdata), .rd_idx(idx_w), .rd_bit(tbl_bit)
  );

  dafilt_decide u_dec (
    .clk(clk), .rst_n(rst_n), .fire(last_w), .addr_w(addr_w), .idx_w(idx_w),
    .tbl_bit(tbl_bit), .sta_lo(sta_lo), .sta_hi(sta_hi), .mc_en(mc_hash_en),
    .bcast_w(bcast_w), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_multicast(dec_multicast), .dec_hash_idx(dec_hash_idx)
  );

  AST_DECISION_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> dec_valid); // R8
  AST_DECISION_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(last_w)); // R8
  AST_BCAST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && bcast_w) |=> dec_accept); // R7
  AST_MC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && !bcast_w && !mc_hash_en && addr_w[0]) |=> !dec_accept); // R5
endmodule

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_start = 1'b0, in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [31:0] sta_lo = 32'h0;
  logic [15:0] sta_hi = 16'h0;
  logic        mc_hash_en = 1'b0;
  logic        tbl_we = 1'b0, tbl_sel = 1'b0;
  logic [31:0] tbl_wdata = '0;
  logic        dec_valid, dec_accept, dec_multicast;
  logic [5:0]  dec_hash_idx;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [63:0] shadow = '0;

  always #2 clk = ~clk;

  dest_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_valid(in_valid),
    .in_byte(in_byte), .sta_lo(sta_lo), .sta_hi(sta_hi), .mc_hash_en(mc_hash_en),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_multicast(dec_multicast), .dec_hash_idx(dec_hash_idx)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reflected-form CRC: shift right with reversed polynomial, then mirror.
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] r;
    logic [5:0] k;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++)
      r = (r[0] ^ a[i]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    r = ~r;
    for (int j = 0; j < 6; j++) k[5-j] = r[j];
    return k;
  endfunction

  function automatic bit ref_accept(input logic [47:0] a);
    if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[0]) return mc_hash_en & shadow[ref_idx(a)];
    return a == {sta_hi, sta_lo};
  endfunction

  task automatic write_word(input bit sel, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
    if (sel) shadow[63:32] = d; else shadow[31:0] = d;
  endtask

  task automatic feed(input logic [47:0] a, input int nbytes, input bit gaps);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = (i == 0); in_byte = a[i*8 +: 8];
      if (gaps && ($urandom % 3 == 0) && i < nbytes - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
      end
    end
  endtask

  task automatic frame(input logic [47:0] a, input bit gaps, input string req);
    bit ea;
    feed(a, 6, gaps);
    ea = ref_accept(a);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
    check(dec_valid === 1'b1, "R8 strobe after sixth byte", dec_valid, 1);
    check(dec_accept === ea, req, dec_accept, ea);
    check(dec_hash_idx === ref_idx(a), "R1 R2 hash index", dec_hash_idx, ref_idx(a));
    check(dec_multicast === a[0], "R8 multicast flag", dec_multicast, a[0]);
    @(negedge clk);
    check(dec_valid === 1'b0, "R8 single-cycle strobe", dec_valid, 0);
  endtask

  initial begin
    logic [47:0] a, sta;
    void'($urandom(32'd20240611));
    sta_lo = 32'h5634_1200; sta_hi = 16'h9A78;
    sta = {sta_hi, sta_lo};
    repeat (4) @(negedge clk);
    check(dec_valid === 1'b0 && dec_accept === 1'b0, "R8 reset state", {dec_valid, dec_accept}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: empty table after reset rejects multicast even when enabled
    mc_hash_en = 1'b1;
    frame(48'h0000_0000_5E01, 1'b0, "R6 empty table rejects multicast");
    frame(48'h1122_3344_5501, 1'b0, "R6 empty table rejects multicast");
    // R7: broadcast with empty table and hash disabled
    mc_hash_en = 1'b0;
    frame(48'hFFFF_FFFF_FFFF, 1'b0, "R7 broadcast always accepted");
    // R4 unicast exact and near misses
    frame(sta, 1'b0, "R4 unicast exact match");
    frame(sta ^ 48'h8000_0000_0000, 1'b0, "R4 unicast byte5 miss");
    frame(sta ^ 48'h0000_0000_0100, 1'b0, "R4 unicast byte1 miss");

    // R3: single bit set in each word in turn
    mc_hash_en = 1'b1;
    a = 48'h0000_0000_5E01;
    begin
      logic [5:0] k;
      k = ref_idx(a);
      write_word(k[5], 32'h1 << k[4:0]);
      write_word(~k[5], 32'h0);
      frame(a, 1'b0, "R3 selected word and bit accept");
      write_word(k[5], 32'h0);
      write_word(~k[5], 32'h1 << k[4:0]);
      frame(a, 1'b0, "R3 other word ignored");
    end

    // R9: restart mid-address discards partial bytes
    write_word(1'b0, 32'h0); write_word(1'b1, 32'h0);
    feed(48'hFFFF_FFFF_FFFF, 3, 1'b0);
    frame(sta ^ 48'h0000_0001_0000, 1'b0, "R9 restart discards partial");
    // R9: stray bytes with no start are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = 1'b0; in_byte = 8'hFF;
      check(dec_valid === 1'b0, "R9 stray bytes ignored", dec_valid, 0);
    end
    @(negedge clk); in_valid = 1'b0;
    check(dec_valid === 1'b0, "R9 stray bytes ignored", dec_valid, 0);
    frame(sta, 1'b0, "R9 clean frame after strays");

    // Random mix: R5 multicast with random tables, R4 unicast, with gaps
    for (int t = 0; t < 120; t++) begin
      if (t % 10 == 0) begin
        write_word(1'b0, $urandom);
        write_word(1'b1, $urandom);
        mc_hash_en = ($urandom % 4) != 0;
      end
      case ($urandom % 4)
        0: a = sta;
        1: begin a = {$urandom, $urandom}; a[0] = 1'b0; end
        default: begin a = {$urandom, $urandom}; a[0] = 1'b1; end
      endcase
      frame(a, ($urandom % 2) == 1, a[0] ? "R5 multicast hash decision" : "R4 unicast decision");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule